// File: doc/BRIEF.md
# Branch Target Prediction Front End

This block forms the fetch-side guess for one control instruction per cycle. The fetch stage presents the instruction address, its class (conditional, unconditional, call, return, direct), the target encoded in a direct instruction, the address-space identifier and the hardware thread. In the same cycle the block answers with a taken bit and the next fetch address. It also returns a small repair record: whether the return stack was used, whether a call pushed onto it, the stack pointer seen, and the popped value.

Three structures feed the decision. The first is a table of two-bit saturating direction counters. The second is a return address stack kept separately for each thread. The third is a direct-mapped target buffer whose entries match on the full instruction address and the address-space identifier, so threads that share an address space also share trained targets. A training port, driven by the resolving stage, moves the direction counters and fills target entries. A parameter selects the branch-delay-slot convention, which changes the address a call pushes and the fall-through address of a conditional branch. Three running counters report lookups, target buffer lookups and target buffer hits. Their ratio gives the hit rate.

Top module: `bp_front`

## Requirements
- R1: An unconditional instruction is predicted without reading the direction counters. An unconditional direct call is always taken, with its own encoded target as the next address, whatever the counter and buffer contents.
- R2: A return whose thread's stack is empty is predicted not taken, with next address PC+4, and the stack is left unchanged.
- R3: A return with a non-empty stack is predicted taken. It pops the top entry, uses it as the next address and reports it in the record with the used-stack flag set. Successive returns see entries in last-in first-out order.
- R4: A predicted-taken call pushes PC+4 when DELAY_SLOT is 0, and PC+8 when DELAY_SLOT is 1.
- R5: Each thread's stack holds 16 entries and its pointer wraps. A push onto a full stack overwrites the oldest entry, so after 17 calls the next 16 returns give the 16 newest addresses in reverse order and the 17th finds the stack empty.
- R6: Any other taken prediction, whether conditional, an unconditional indirect jump or an indirect call, needs a buffer entry (64 entries, index PC[7:2]) that matches both the whole PC and the address-space identifier. A miss forces the prediction to not taken. The buffer does not look at the thread number.
- R7: A not-taken conditional branch gives next address PC+4 with DELAY_SLOT 0 and PC+8 with DELAY_SLOT 1. Every other not-taken case gives PC+4.
- R8: The direction table holds 256 two-bit counters indexed by PC[9:2]. Each resets to 1. A conditional predicts taken when its counter is 2 or more. Training with a conditional outcome moves the counter by one and saturates at 0 and 3.
- R9: The lookup counter rises by one for each valid lookup. The buffer-lookup counter rises for each taken candidate that is not a return. The hit counter rises when such a candidate's target comes from a matching buffer entry.
- R10: With the lookup valid low, the prediction is not taken, the next address is PC+4, and no counter or stack changes.
- R11: After reset all statistics are zero, every stack is empty and every buffer entry is invalid.
- R12: Stacks are private to a thread. Calls on one thread never give a target to a return on another thread.
- R13: A training event with its taken bit set writes the buffer entry for its PC with its identifier and target. A training event marked conditional also moves that PC's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_pc | input | PC_W | Instruction address |
| lk_cond | input | 1 | Conditional branch |
| lk_uncond | input | 1 | Unconditional control |
| lk_call | input | 1 | Call |
| lk_ret | input | 1 | Return |
| lk_direct | input | 1 | Target encoded in the instruction |
| lk_direct_tgt | input | PC_W | Encoded target |
| lk_asid | input | ASID_W | Address-space identifier |
| lk_tid | input | TID_W | Hardware thread |
| pr_taken | output | 1 | Predicted taken |
| pr_next_pc | output | PC_W | Predicted next fetch address |
| rec_used_ras | output | 1 | Return stack supplied the target |
| rec_was_call | output | 1 | This lookup pushed onto the stack |
| rec_ras_idx | output | RAS_IW | Thread's stack pointer before the lookup |
| rec_ras_val | output | PC_W | Popped value, zero when unused |
| tr_valid | input | 1 | Training event |
| tr_pc | input | PC_W | Trained instruction address |
| tr_asid | input | ASID_W | Trained identifier |
| tr_cond | input | 1 | Event moves the direction counter |
| tr_taken | input | 1 | Resolved outcome taken |
| tr_tgt | input | PC_W | Resolved target |
| st_lookups | output | STAT_W | Lookup count |
| st_btb_lookups | output | STAT_W | Buffer lookup count |
| st_btb_hits | output | STAT_W | Buffer hit count |

## Verification
On every cycle the assertions check these points: no stack is popped while empty, the stack occupancy grows on a push below capacity, counters saturate, a written buffer entry becomes valid, and hits never outnumber buffer lookups. They also check that a return on an empty stack is never taken and that a taken non-return prediction without an encoded call target always has a buffer hit. The bench scenarios cover the rest. They show the stack contents in last-in first-out order and the loss of the oldest entry on overflow. They show identifier matching, including sharing across threads. They show the exact next addresses under both delay-slot settings and the thread privacy of the stacks.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        RAS_IDLE = 2'd0,
        RAS_PUSH = 2'd1,
        RAS_POP  = 2'd2
    } ras_op_e;

    localparam logic [1:0] CTR_INIT = 2'd1;

    function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        else    return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic ctr_taken(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/bp_dir.sv
module bp_dir
    import bp_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_taken,
    input  logic          upd_en,
    input  logic [IW-1:0] upd_idx,
    input  logic          upd_taken
);

    logic [1:0] ctr_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_next(ctr_q[upd_idx], upd_taken);
        end
    end

    assign rd_taken = ctr_taken(ctr_q[rd_idx]);

    AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_taken && ctr_q[upd_idx] == 2'd3) |=> (ctr_q[$past(upd_idx)] == 2'd3)); // R8
    AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_taken && ctr_q[upd_idx] == 2'd0) |=> (ctr_q[$past(upd_idx)] == 2'd0)); // R8

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
    parameter int PC_W       = 32,
    parameter int ASID_W     = 8,
    parameter int ENTRIES    = 64,
    parameter int INSN_BYTES = 4,
    localparam int OFF  = $clog2(INSN_BYTES),
    localparam int IW   = $clog2(ENTRIES),
    localparam int TAGW = PC_W - IW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   rd_pc,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              rd_hit,
    output logic [PC_W-1:0]   rd_tgt,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PC_W-1:0]   wr_tgt
);

    logic              vld_q  [ENTRIES];
    logic [TAGW-1:0]   tag_q  [ENTRIES];
    logic [ASID_W-1:0] asid_q [ENTRIES];
    logic [PC_W-1:0]   tgt_q  [ENTRIES];

    function automatic logic [TAGW-1:0] tag_of(input logic [PC_W-1:0] pc);
        return {pc[PC_W-1:OFF+IW], pc[OFF-1:0]};
    endfunction

    logic [IW-1:0] rd_idx, wr_idx;
    assign rd_idx = rd_pc[OFF +: IW];
    assign wr_idx = wr_pc[OFF +: IW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= tag_of(wr_pc);
            asid_q[wr_idx] <= wr_asid;
            tgt_q[wr_idx]  <= wr_tgt;
        end
    end

    assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc))
                    && (asid_q[rd_idx] == rd_asid);
    assign rd_tgt = tgt_q[rd_idx];

    AST_BTB_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)]); // R13

endmodule

// File: rtl/bp_ras.sv
module bp_ras
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int NTHR  = 2,
    parameter int DEPTH = 16,
    localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   tid_i,
    input  ras_op_e         op_i,
    input  logic [PC_W-1:0] push_val_i,
    output logic [PC_W-1:0] top_val_o,
    output logic [PW-1:0]   top_idx_o,
    output logic            empty_o
);

    logic [PC_W-1:0] mem_q [NTHR][DEPTH];
    logic [PW-1:0]   ptr_q [NTHR];
    logic [CW-1:0]   cnt_q [NTHR];

    logic [PW-1:0] ptr_sel, ptr_inc, ptr_dec;
    logic [CW-1:0] cnt_sel;

    assign ptr_sel = ptr_q[tid_i];
    assign cnt_sel = cnt_q[tid_i];
    assign ptr_inc = ptr_sel + PW'(1);
    assign ptr_dec = ptr_sel - PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NTHR; t++) begin
                ptr_q[t] <= '0;
                cnt_q[t] <= '0;
            end
        end else begin
            case (op_i)
                RAS_PUSH: begin
                    ptr_q[tid_i] <= ptr_inc;
                    if (cnt_sel != CW'(DEPTH)) cnt_q[tid_i] <= cnt_sel + CW'(1);
                end
                RAS_POP: begin
                    ptr_q[tid_i] <= ptr_dec;
                    cnt_q[tid_i] <= cnt_sel - CW'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (op_i == RAS_PUSH) mem_q[tid_i][ptr_inc] <= push_val_i;
    end

    assign top_val_o = mem_q[tid_i][ptr_sel];
    assign top_idx_o = ptr_sel;
    assign empty_o   = (cnt_sel == '0);

    AST_RAS_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (op_i == RAS_POP) |-> (cnt_sel != '0)); // R2
    AST_RAS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_sel <= CW'(DEPTH)); // R5
    AST_RAS_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (op_i == RAS_PUSH && cnt_sel < CW'(DEPTH))
        |=> (cnt_q[$past(tid_i)] == $past(cnt_sel) + CW'(1))); // R4

endmodule

// File: rtl/bp_front.sv
module bp_front
    import bp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int ASID_W      = 8,
    parameter int NTHR        = 2,
    parameter int RAS_DEPTH   = 16,
    parameter int BTB_ENTRIES = 64,
    parameter int DIR_ENTRIES = 256,
    parameter int INSN_BYTES  = 4,
    parameter int DELAY_SLOT  = 0,
    parameter int STAT_W      = 32,
    localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int RAS_IW = $clog2(RAS_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic              lk_cond,
    input  logic              lk_uncond,
    input  logic              lk_call,
    input  logic              lk_ret,
    input  logic              lk_direct,
    input  logic [PC_W-1:0]   lk_direct_tgt,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [TID_W-1:0]  lk_tid,
    output logic              pr_taken,
    output logic [PC_W-1:0]   pr_next_pc,
    output logic              rec_used_ras,
    output logic              rec_was_call,
    output logic [RAS_IW-1:0] rec_ras_idx,
    output logic [PC_W-1:0]   rec_ras_val,
    input  logic              tr_valid,
    input  logic [PC_W-1:0]   tr_pc,
    input  logic [ASID_W-1:0] tr_asid,
    input  logic              tr_cond,
    input  logic              tr_taken,
    input  logic [PC_W-1:0]   tr_tgt,
    output logic [STAT_W-1:0] st_lookups,
    output logic [STAT_W-1:0] st_btb_lookups,
    output logic [STAT_W-1:0] st_btb_hits
);

    localparam int OFF    = $clog2(INSN_BYTES);
    localparam int DIR_IW = $clog2(DIR_ENTRIES);

    logic [PC_W-1:0] seq_pc, skip_pc, push_val;
    assign seq_pc   = lk_pc + PC_W'(INSN_BYTES);
    assign skip_pc  = lk_pc + PC_W'(2 * INSN_BYTES);
    assign push_val = (DELAY_SLOT != 0) ? skip_pc : seq_pc;

    logic            dir_taken;
    logic            btb_hit;
    logic [PC_W-1:0] btb_tgt;
    logic [PC_W-1:0] ras_top;
    logic            ras_empty;
    ras_op_e         ras_op;

    bp_dir #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_pc[OFF +: DIR_IW]),
        .rd_taken  (dir_taken),
        .upd_en    (tr_valid && tr_cond),
        .upd_idx   (tr_pc[OFF +: DIR_IW]),
        .upd_taken (tr_taken)
    );

    bp_btb #(.PC_W(PC_W), .ASID_W(ASID_W), .ENTRIES(BTB_ENTRIES),
             .INSN_BYTES(INSN_BYTES)) u_btb (
        .clk     (clk),
        .rst     (rst),
        .rd_pc   (lk_pc),
        .rd_asid (lk_asid),
        .rd_hit  (btb_hit),
        .rd_tgt  (btb_tgt),
        .wr_en   (tr_valid && tr_taken),
        .wr_pc   (tr_pc),
        .wr_asid (tr_asid),
        .wr_tgt  (tr_tgt)
    );

    bp_ras #(.PC_W(PC_W), .NTHR(NTHR), .DEPTH(RAS_DEPTH)) u_ras (
        .clk        (clk),
        .rst        (rst),
        .tid_i      (lk_tid),
        .op_i       (ras_op),
        .push_val_i (push_val),
        .top_val_o  (ras_top),
        .top_idx_o  (rec_ras_idx),
        .empty_o    (ras_empty)
    );

    logic            taken, btb_lk, btb_used, used_ras, was_call;
    logic [PC_W-1:0] tgt;

    always_comb begin
        ras_op   = RAS_IDLE;
        taken    = 1'b0;
        tgt      = seq_pc;
        btb_lk   = 1'b0;
        btb_used = 1'b0;
        used_ras = 1'b0;
        was_call = 1'b0;
        if (lk_valid) begin
            taken = lk_uncond ? 1'b1 : dir_taken;
            if (taken) begin
                if (lk_ret) begin
                    if (ras_empty) begin
                        taken = 1'b0;
                    end else begin
                        tgt      = ras_top;
                        ras_op   = RAS_POP;
                        used_ras = 1'b1;
                    end
                end else begin
                    btb_lk = 1'b1;
                    if (lk_call) begin
                        ras_op   = RAS_PUSH;
                        was_call = 1'b1;
                    end
                    if (lk_call && lk_direct) begin
                        tgt = lk_direct_tgt;
                    end else if (btb_hit) begin
                        tgt      = btb_tgt;
                        btb_used = 1'b1;
                    end else begin
                        taken = 1'b0;
                    end
                end
            end
        end
    end

    assign pr_taken     = taken;
    assign pr_next_pc   = taken ? tgt
                        : ((DELAY_SLOT != 0 && lk_valid && lk_cond && !lk_uncond) ? skip_pc : seq_pc);
    assign rec_used_ras = used_ras;
    assign rec_was_call = was_call;
    assign rec_ras_val  = used_ras ? ras_top : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_lookups     <= '0;
            st_btb_lookups <= '0;
            st_btb_hits    <= '0;
        end else begin
            if (lk_valid) st_lookups     <= st_lookups + STAT_W'(1);
            if (btb_lk)   st_btb_lookups <= st_btb_lookups + STAT_W'(1);
            if (btb_used) st_btb_hits    <= st_btb_hits + STAT_W'(1);
        end
    end

    AST_LOOKUP_STEP: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (st_lookups == $past(st_lookups) + STAT_W'(1))); // R9
    AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        st_btb_hits <= st_btb_lookups); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> $stable(st_lookups) && $stable(st_btb_lookups)); // R10
    AST_RET_EMPTY_NT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ret && ras_empty) |-> !pr_taken); // R2
    AST_TAKEN_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        (pr_taken && !lk_ret && !(lk_call && lk_direct)) |-> btb_hit); // R6

endmodule

// File: tb/tb_bp_front.sv
`timescale 1ns/1ps
module tb_bp_front;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        lk_valid = 0, lk_cond = 0, lk_uncond = 0, lk_call = 0, lk_ret = 0, lk_direct = 0;
    logic [31:0] lk_pc = 0, lk_direct_tgt = 0;
    logic [7:0]  lk_asid = 0;
    logic [0:0]  lk_tid = 0;
    logic        tr_valid = 0, tr_cond = 0, tr_taken = 0;
    logic [31:0] tr_pc = 0, tr_tgt = 0;
    logic [7:0]  tr_asid = 0;

    logic        pr_taken, rec_used_ras, rec_was_call;
    logic [31:0] pr_next_pc, rec_ras_val, st_lookups, st_btb_lookups, st_btb_hits;
    logic [3:0]  rec_ras_idx;
    logic        ds_taken, ds_used, ds_call;
    logic [31:0] ds_next, ds_val, ds_lk, ds_bl, ds_bh;
    logic [3:0]  ds_idx;

    bp_front dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_cond(lk_cond),
        .lk_uncond(lk_uncond), .lk_call(lk_call), .lk_ret(lk_ret), .lk_direct(lk_direct),
        .lk_direct_tgt(lk_direct_tgt), .lk_asid(lk_asid), .lk_tid(lk_tid),
        .pr_taken(pr_taken), .pr_next_pc(pr_next_pc), .rec_used_ras(rec_used_ras),
        .rec_was_call(rec_was_call), .rec_ras_idx(rec_ras_idx), .rec_ras_val(rec_ras_val),
        .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_asid(tr_asid), .tr_cond(tr_cond),
        .tr_taken(tr_taken), .tr_tgt(tr_tgt), .st_lookups(st_lookups),
        .st_btb_lookups(st_btb_lookups), .st_btb_hits(st_btb_hits));

    bp_front #(.DELAY_SLOT(1)) dut_ds (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_cond(lk_cond),
        .lk_uncond(lk_uncond), .lk_call(lk_call), .lk_ret(lk_ret), .lk_direct(lk_direct),
        .lk_direct_tgt(lk_direct_tgt), .lk_asid(lk_asid), .lk_tid(lk_tid),
        .pr_taken(ds_taken), .pr_next_pc(ds_next), .rec_used_ras(ds_used),
        .rec_was_call(ds_call), .rec_ras_idx(ds_idx), .rec_ras_val(ds_val),
        .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_asid(tr_asid), .tr_cond(tr_cond),
        .tr_taken(tr_taken), .tr_tgt(tr_tgt), .st_lookups(ds_lk),
        .st_btb_lookups(ds_bl), .st_btb_hits(ds_bh));

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [31:0] ras0[$], ras1[$];
    bit          m_v[64];
    logic [31:0] m_pc[64], m_tgt[64];
    logic [7:0]  m_asid[64];
    int          m_dir[256];
    int          e_lk = 0, e_bl = 0, e_bh = 0;

    localparam int C_COND = 0, C_JMP = 1, C_DCALL = 2, C_ICALL = 3, C_RET = 4;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic model_reset();
        ras0.delete(); ras1.delete();
        for (int i = 0; i < 64; i++) m_v[i] = 0;
        for (int i = 0; i < 256; i++) m_dir[i] = 1;
        e_lk = 0; e_bl = 0; e_bh = 0;
    endtask

    // one lookup; ds_chk enables a check of the delay-slot instance's next address
    task automatic lookup(input int cls, input logic [31:0] pc, input logic [31:0] dtgt,
                          input logic [7:0] asid, input bit tid, input string rq,
                          input bit ds_chk = 0, input logic [31:0] ds_exp = 0);
        bit et, eused, uncond, call, ret;
        logic [31:0] etg, eval;
        int bi;
        uncond = (cls != C_COND);
        call   = (cls == C_DCALL || cls == C_ICALL);
        ret    = (cls == C_RET);
        @(negedge clk);
        lk_valid = 1; lk_pc = pc; lk_direct_tgt = dtgt; lk_asid = asid; lk_tid = tid;
        lk_cond = !uncond; lk_uncond = uncond; lk_call = call; lk_ret = ret;
        lk_direct = (cls == C_DCALL);
        #1;
        eused = 0; eval = 0; etg = pc + 4;
        bi = pc[7:2];
        et = uncond ? 1'b1 : (m_dir[pc[9:2]] >= 2);
        if (et) begin
            if (ret) begin
                if ((tid ? ras1.size() : ras0.size()) == 0) et = 0;
                else begin
                    eval = tid ? ras1.pop_back() : ras0.pop_back();
                    etg = eval; eused = 1;
                end
            end else begin
                e_bl++;
                if (call) begin
                    if (tid) begin ras1.push_back(pc + 4); if (ras1.size() > 16) void'(ras1.pop_front()); end
                    else     begin ras0.push_back(pc + 4); if (ras0.size() > 16) void'(ras0.pop_front()); end
                end
                if (cls == C_DCALL) etg = dtgt;
                else if (m_v[bi] && m_pc[bi] == pc && m_asid[bi] == asid) begin etg = m_tgt[bi]; e_bh++; end
                else et = 0;
            end
        end
        e_lk++;
        if (!et) etg = pc + 4;
        chk({rq, " taken"}, {31'd0, pr_taken}, {31'd0, et});
        chk({rq, " next"}, pr_next_pc, etg);
        if (ret) begin
            chk({rq, " used_ras"}, {31'd0, rec_used_ras}, {31'd0, eused});
            chk({rq, " ras_val"}, rec_ras_val, eval);
        end
        if (ds_chk) chk({rq, " delay-slot next"}, ds_next, ds_exp);
        @(posedge clk); #1;
        lk_valid = 0;
    endtask

    task automatic train(input logic [31:0] pc, input logic [7:0] asid, input bit cond,
                         input bit tk, input logic [31:0] tgt);
        @(negedge clk);
        tr_valid = 1; tr_pc = pc; tr_asid = asid; tr_cond = cond; tr_taken = tk; tr_tgt = tgt;
        @(posedge clk); #1;
        tr_valid = 0;
        if (cond) begin
            if (tk && m_dir[pc[9:2]] < 3) m_dir[pc[9:2]]++;
            if (!tk && m_dir[pc[9:2]] > 0) m_dir[pc[9:2]]--;
        end
        if (tk) begin
            m_v[pc[7:2]] = 1; m_pc[pc[7:2]] = pc; m_asid[pc[7:2]] = asid; m_tgt[pc[7:2]] = tgt;
        end
    endtask

    task automatic chk_stats(input string rq);
        chk({rq, " lookups"}, st_lookups, e_lk);
        chk({rq, " btb lookups"}, st_btb_lookups, e_bl);
        chk({rq, " btb hits"}, st_btb_hits, e_bh);
    endtask

    initial begin
        int s0, s1, s2;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R11 reset state
        chk_stats("R11");
        lookup(C_RET, 32'h40, 0, 8'd1, 0, "R2 R11 empty return", 1, 32'h44);
        lookup(C_COND, 32'h80, 0, 8'd1, 0, "R8 R7 reset counter", 1, 32'h88);
        lookup(C_JMP, 32'h90, 0, 8'd1, 0, "R6 R11 jump miss");

        // R1 direct call, R4 push and R3 pop under both conventions
        lookup(C_DCALL, 32'h100, 32'h2000, 8'd1, 0, "R1 direct call", 1, 32'h2000);
        lookup(C_RET, 32'h3000, 0, 8'd1, 0, "R3 R4 return", 1, 32'h108);

        // R5 overflow: 17 calls then 17 returns
        for (int i = 0; i < 17; i++) lookup(C_DCALL, 32'h1000 + 32'(i * 16), 32'h5000, 8'd1, 0, "R5 call");
        for (int i = 0; i < 17; i++) lookup(C_RET, 32'h6000, 0, 8'd1, 0, "R5 return");

        // R12 thread privacy
        lookup(C_DCALL, 32'h700, 32'h7100, 8'd1, 0, "R12 call tid0");
        lookup(C_RET, 32'h7200, 0, 8'd1, 1, "R12 return tid1");
        lookup(C_RET, 32'h7204, 0, 8'd1, 0, "R12 R3 return tid0");

        // R6 R8 R13 identifier match, sharing across threads, counter saturation
        train(32'h400, 8'd3, 1, 1, 32'h8000);
        lookup(C_COND, 32'h400, 0, 8'd3, 0, "R6 R13 hit");
        lookup(C_COND, 32'h400, 0, 8'd4, 0, "R6 asid miss");
        lookup(C_COND, 32'h400, 0, 8'd3, 1, "R6 other thread shares");
        lookup(C_COND, 32'h1400, 0, 8'd3, 0, "R6 tag miss");
        repeat (3) train(32'h400, 8'd3, 1, 0, 32'h0);
        train(32'h400, 8'd3, 1, 1, 32'h8000);
        lookup(C_COND, 32'h400, 0, 8'd3, 0, "R8 low saturation");
        repeat (3) train(32'h400, 8'd3, 1, 1, 32'h8000);
        train(32'h400, 8'd3, 1, 0, 32'h0);
        lookup(C_COND, 32'h400, 0, 8'd3, 0, "R8 high saturation");

        // R1 unconditional indirect jump ignores a weak counter
        train(32'h484, 8'd3, 0, 1, 32'h9000);
        lookup(C_JMP, 32'h484, 0, 8'd3, 0, "R1 jump with weak counter");
        lookup(C_COND, 32'h484, 0, 8'd3, 0, "R8 R13 untouched counter");
        lookup(C_ICALL, 32'h484, 0, 8'd3, 0, "R4 indirect call");
        lookup(C_RET, 32'h9100, 0, 8'd3, 0, "R3 after indirect call");
        chk_stats("R9 directed");

        // R10 idle cycles
        @(negedge clk);
        lk_valid = 0; lk_pc = 32'h400; lk_cond = 1; lk_uncond = 0; lk_asid = 8'd3;
        #1;
        chk("R10 idle taken", {31'd0, pr_taken}, 32'd0);
        chk("R10 idle next", pr_next_pc, 32'h404);
        repeat (5) @(posedge clk);
        #1 chk_stats("R10");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            s0 = $urandom % 10;
            s1 = $urandom % 16;
            s2 = $urandom % 2;
            if (s0 < 4) begin
                train((s2 ? 32'h400 : 32'h1400) + 32'(s1 * 4), 8'($urandom % 2 + 1),
                      $urandom % 2, $urandom % 2, {$urandom % 32'h10000, 2'b00});
            end else begin
                lookup((s0 < 6) ? C_COND : (s0 % 5), (s2 ? 32'h400 : 32'h1400) + 32'(s1 * 4),
                       {$urandom % 32'h10000, 2'b00}, 8'($urandom % 2 + 1), $urandom % 2, "R6 R3 random");
            end
        end
        chk_stats("R9 random");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

endmodule